// File: doc/BRIEF.md
# Ring-Buffer Register Command Pusher

This block is a bus-master command replayer. Software builds a stream of 32-bit words in a power-of-two ring held in system memory and then advances a PUT offset. The block fetches words one at a time from `base + GET` and turns them into register writes on a simple write port. It advances GET past every word it consumes and stops when GET catches up with PUT.

The stream is a sequence of packets. Each packet opens with a header word that holds a starting register byte offset and a count of data words. The data words that follow go to consecutive 32-bit registers: the starting offset, then offset + 4, and so on. A write to the command register offset has the same effect as a direct host write to that register. So that an operation cannot be started while the target is still busy, such a write is held back until the target reports idle.

Control is through a small configuration port with four entries: enable, ring base, ring size and PUT. The current GET offset is available on an output at all times.

Top module: `cmd_ring_pusher`

## Requirements
- R1: A header word holds the data-word count in bits 31..16 and the starting register byte offset in bits 15..0. The two low bits of the offset are taken as zero.
- R2: The N data words after a header are written in stream order to offsets start, start+4, start+8 and onward. Exactly one write is issued for each data word.
- R3: GET advances by 4 bytes for every word consumed, headers included. It wraps to 0 when it reaches the ring size (configuration entry 2, a power of two in bytes).
- R4: Words are fetched only while enable (entry 0, bit 0) is set and GET differs from PUT. Once GET equals PUT, no further fetch request is raised.
- R5: Each fetch address is ring base + GET. The base (entry 1) keeps its low 4 bits at zero. The fetch request stays high with a stable address until a read-valid returns the word.
- R6: A header with count 0 is consumed and produces no register write. The next word is then treated as a header.
- R7: A register write stays valid, with stable offset and data, until the target accepts it with ready. At most one write completes per cycle.
- R8: A write to the command offset (0x150) is not presented while the target is busy. It completes once busy drops.
- R9: Clearing enable stops fetching after the word in flight. GET keeps its value, and setting enable again resumes from that point.
- R10: A write to PUT (entry 3) ignores bits 1..0 of the written value.
- R11: After reset GET is 0, enable is clear, and neither a fetch request nor a register write is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration entry: 0 enable, 1 base, 2 size, 3 PUT |
| cfg_wdata | input | 32 | Configuration write data |
| ring_get | output | PTR_W | Current GET byte offset |
| mem_req | output | 1 | Fetch request, held until mem_rvalid |
| mem_addr | output | ADDR_W | Fetch byte address |
| mem_rvalid | input | 1 | Fetched word is valid |
| mem_rdata | input | 32 | Fetched word |
| wr_valid | output | 1 | Register write valid |
| wr_offset | output | 16 | Register byte offset |
| wr_data | output | 32 | Register write data |
| wr_ready | input | 1 | Target accepts the write |
| tgt_busy | input | 1 | Target operation in progress |

## Verification
The bench builds the block with PTR_W = 8 and ADDR_W = 32, and programs a ring size of 32 bytes. With a ring of only eight words, a packet can straddle the wrap point after a few packets, and the bench checks that GET returns to 0 partway through a packet. A base written with stray low bits, a PUT written with stray low bits, and a command-offset write issued while the target is busy are all reached within one short run. A memory model with fixed latency and a toggling ready exercise both handshakes.

// File: rtl/pusher_pkg.sv
// Shared definitions for the ring command pusher.
// Assumes 32-bit ring words and 16-bit register offsets.
package pusher_pkg;

    localparam int WORD_W     = 32;
    localparam int OFS_W      = 16;
    localparam int CNT_W      = 16;
    localparam int HDR_CNT_LSB = 16;

    // Configuration entry selectors
    localparam logic [1:0] CFG_ENABLE = 2'd0;
    localparam logic [1:0] CFG_BASE   = 2'd1;
    localparam logic [1:0] CFG_SIZE   = 2'd2;
    localparam logic [1:0] CFG_PUT    = 2'd3;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_FETCH = 2'd1,
        PS_WRITE = 2'd2
    } pusher_state_e;

endpackage

// File: rtl/pusher_cfg.sv
// Configuration registers: enable, ring base, ring size and PUT.
// Assumes the size is written as a power of two in bytes. The base is
// forced to 16-byte alignment and PUT to word alignment.
module pusher_cfg
    import pusher_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              enable,
    output logic [ADDR_W-1:0] base,
    output logic [PTR_W-1:0]  size_mask,
    output logic [PTR_W-1:0]  put
);

    logic [PTR_W-1:0] size_q;

    // Capture host writes into the selected entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            base   <= '0;
            size_q <= '0;
            put    <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_ENABLE: enable <= cfg_wdata[0];
                CFG_BASE:   base   <= {cfg_wdata[ADDR_W-1:4], 4'b0000};
                CFG_SIZE:   size_q <= cfg_wdata[PTR_W-1:0];
                default:    put    <= {cfg_wdata[PTR_W-1:2], 2'b00};
            endcase
        end
    end

    // Wrap mask for a power-of-two ring size
    always_comb size_mask = size_q - PTR_W'(1);

    wire unused_cfg_bits = ^cfg_wdata;

    // R10: PUT never holds a byte-misaligned offset
    a_r10_put_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        put[1:0] == 2'b00);

endmodule

// File: rtl/pusher_getptr.sv
// GET pointer: advances one word per consumed entry and wraps at the ring size.
// Assumes size_mask is size minus one, with size a power of two.
module pusher_getptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [PTR_W-1:0] size_mask,
    input  logic [PTR_W-1:0] put,
    output logic [PTR_W-1:0] get,
    output logic             drained
);

    // Advance and wrap GET on each consumed word
    always_ff @(posedge clk) begin
        if (!rst_n)
            get <= '0;
        else if (step)
            get <= (get + PTR_W'(4)) & size_mask;
    end

    // Ring drained when GET reaches PUT
    always_comb drained = (get == put);

    // R3: any change of GET is a single word step, modulo the ring size
    a_r3_get_step: assert property (@(posedge clk) disable iff (!rst_n)
        (get != $past(get)) && $stable(size_mask)
        |-> get == (($past(get) + PTR_W'(4)) & size_mask));

endmodule

// File: rtl/pusher_seq.sv
// Sequencer: fetches ring words, decodes headers, and issues register writes.
// Assumes one fetch in flight at a time and a fetch request held until the
// read-valid returns.
module pusher_seq
    import pusher_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          PTR_W   = 16,
    parameter logic [15:0] CMD_OFS = 16'h0150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              drained,
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  get,
    output logic              step,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wr_valid,
    output logic [OFS_W-1:0]  wr_offset,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    input  logic              tgt_busy
);

    pusher_state_e     state;
    logic [CNT_W-1:0]  remain;
    logic [OFS_W-1:0]  ofs;
    logic [WORD_W-1:0] wdata;
    logic              is_cmd;

    // Fetch and write-port outputs derived from state
    always_comb begin
        mem_req   = (state == PS_FETCH);
        mem_addr  = base + ADDR_W'(get);
        step      = mem_req && mem_rvalid;
        is_cmd    = (ofs == CMD_OFS);
        wr_valid  = (state == PS_WRITE) && !(is_cmd && tgt_busy);
        wr_offset = ofs;
        wr_data   = wdata;
    end

    // Packet state machine: header decode, data capture, write completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_IDLE;
            remain <= '0;
            ofs    <= '0;
            wdata  <= '0;
        end else begin
            case (state)
                PS_IDLE: begin
                    if (enable && !drained)
                        state <= PS_FETCH;
                end
                PS_FETCH: begin
                    if (mem_rvalid) begin
                        if (remain == '0) begin
                            remain <= mem_rdata[HDR_CNT_LSB +: CNT_W];
                            ofs    <= {mem_rdata[OFS_W-1:2], 2'b00};
                            state  <= PS_IDLE;
                        end else begin
                            wdata <= mem_rdata;
                            state <= PS_WRITE;
                        end
                    end
                end
                PS_WRITE: begin
                    if (wr_valid && wr_ready) begin
                        ofs    <= ofs + OFS_W'(4);
                        remain <= remain - CNT_W'(1);
                        state  <= PS_IDLE;
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    // R4: a fetch starts only from an enabled, non-drained ring
    a_r4_fetch_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(enable) && !$past(drained));

    // R5: the fetch request holds with a stable address until data returns
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    // R7: a stalled non-command write keeps its offset and data
    a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready && (wr_offset != CMD_OFS)
        |=> wr_valid && $stable(wr_offset) && $stable(wr_data));

    // R8: no command-offset write is presented while the target is busy
    a_r8_cmd_wait: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_offset == CMD_OFS) |-> !tgt_busy);

endmodule

// File: rtl/cmd_ring_pusher.sv
// Top level of the ring command pusher: configuration, GET pointer and
// sequencer. Assumes a single-beat word read port and a register write port
// with ready backpressure.
module cmd_ring_pusher
    import pusher_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          PTR_W   = 16,
    parameter logic [15:0] CMD_OFS = 16'h0150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [PTR_W-1:0]  ring_get,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              wr_valid,
    output logic [15:0]       wr_offset,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    input  logic              tgt_busy
);

    logic              enable;
    logic [ADDR_W-1:0] base;
    logic [PTR_W-1:0]  size_mask;
    logic [PTR_W-1:0]  put;
    logic              step;
    logic              drained;

    pusher_cfg #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .enable    (enable),
        .base      (base),
        .size_mask (size_mask),
        .put       (put)
    );

    pusher_getptr #(.PTR_W(PTR_W)) u_get (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .size_mask (size_mask),
        .put       (put),
        .get       (ring_get),
        .drained   (drained)
    );

    pusher_seq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CMD_OFS(CMD_OFS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .drained    (drained),
        .base       (base),
        .get        (ring_get),
        .step       (step),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .wr_valid   (wr_valid),
        .wr_offset  (wr_offset),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .tgt_busy   (tgt_busy)
    );

    // R11: nothing is requested or written while disabled and drained at rest
    a_r11_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !mem_req && !wr_valid && ring_get == '0);

endmodule

// File: tb/cmd_ring_pusher_tb.sv
module cmd_ring_pusher_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PTR_W      = 8;
    localparam int ADDR_W     = 32;
    localparam int MEM_LAT    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [PTR_W-1:0]  ring_get;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              wr_valid;
    logic [15:0]       wr_offset;
    logic [31:0]       wr_data;
    logic              wr_ready;
    logic              tgt_busy = 1'b0;

    logic              ready_mode = 1'b0;
    logic              ready_tgl = 1'b0;
    int                lat_cnt = 0;
    logic [31:0]       mem [0:63];
    logic [15:0]       log_ofs [0:31];
    logic [31:0]       log_dat [0:31];
    int                nlog = 0;
    int                errors = 0;
    int                checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign wr_ready = ready_mode ? ready_tgl : 1'b1;

    cmd_ring_pusher #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ring_get(ring_get), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_valid(wr_valid), .wr_offset(wr_offset), .wr_data(wr_data),
        .wr_ready(wr_ready), .tgt_busy(tgt_busy)
    );

    // Ready toggles away from the active edge
    always @(negedge clk) ready_tgl <= ~ready_tgl;

    // Memory model: fixed latency, one word per request
    always @(posedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            lat_cnt    <= 0;
        end else if (mem_req) begin
            if (lat_cnt == MEM_LAT) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[7:2]];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Log accepted register writes
    always @(posedge clk) begin
        if (rst_n && wr_valid && wr_ready && nlog < 32) begin
            log_ofs[nlog] <= wr_offset;
            log_dat[nlog] <= wr_data;
            nlog <= nlog + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_get(input logic [PTR_W-1:0] target);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (ring_get == target && !mem_req && !wr_valid) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R11 get after reset", 32'(ring_get), 32'h0);
        check("R11 mem_req after reset", 32'(mem_req), 32'h0);
        check("R11 wr_valid after reset", 32'(wr_valid), 32'h0);
    endtask

    task automatic t_basic;
        mem[0] = 32'h0003_0100;
        mem[1] = 32'hA000_0001;
        mem[2] = 32'hA000_0002;
        mem[3] = 32'hA000_0003;
        cfg_write(2'd1, 32'h0000_010B);  // R5 base low bits dropped
        cfg_write(2'd2, 32'd32);
        cfg_write(2'd0, 32'd1);
        cfg_write(2'd3, 32'd16);
        wait_get(8'd16);
        check("R2 write count", 32'(nlog), 32'd3);
        check("R1 first offset", 32'(log_ofs[0]), 32'h100);
        check("R2 second offset", 32'(log_ofs[1]), 32'h104);
        check("R2 third offset", 32'(log_ofs[2]), 32'h108);
        check("R5 first data via base+GET", log_dat[0], 32'hA000_0001);
        check("R2 third data", log_dat[2], 32'hA000_0003);
        check("R3 get after packet", 32'(ring_get), 32'd16);
    endtask

    task automatic t_zero_count;
        mem[4] = 32'h0000_0040;
        mem[5] = 32'h0001_0202;  // R1 offset low bits dropped
        mem[6] = 32'hB000_0001;
        cfg_write(2'd3, 32'd28);
        wait_get(8'd28);
        check("R6 only one write", 32'(nlog), 32'd4);
        check("R1 offset after empty header", 32'(log_ofs[3]), 32'h200);
        check("R6 data after empty header", log_dat[3], 32'hB000_0001);
    endtask

    task automatic t_wrap;
        ready_mode = 1'b1;
        mem[7] = 32'h0002_0300;
        mem[0] = 32'hC000_0001;
        mem[1] = 32'hC000_0002;
        cfg_write(2'd3, 32'd8);
        wait_get(8'd8);
        ready_mode = 1'b0;
        check("R3 get after wrap", 32'(ring_get), 32'd8);
        check("R7 writes under backpressure", 32'(nlog), 32'd6);
        check("R7 wrapped offset 0", 32'(log_ofs[4]), 32'h300);
        check("R7 wrapped data 0", log_dat[4], 32'hC000_0001);
        check("R2 wrapped offset 1", 32'(log_ofs[5]), 32'h304);
        check("R2 wrapped data 1", log_dat[5], 32'hC000_0002);
    endtask

    task automatic t_put_bits;
        mem[2] = 32'h0000_0010;
        cfg_write(2'd3, 32'h0000_000F);
        wait_get(8'h0C);
        check("R10 get stops at masked put", 32'(ring_get), 32'h0C);
        repeat (10) @(negedge clk);
        check("R4 get held when drained", 32'(ring_get), 32'h0C);
        check("R4 no fetch when drained", 32'(mem_req), 32'h0);
        check("R6 no writes from empty header", 32'(nlog), 32'd6);
    endtask

    task automatic t_enable;
        cfg_write(2'd0, 32'd0);
        mem[3] = 32'h0001_0020;
        mem[4] = 32'hD000_0001;
        cfg_write(2'd3, 32'h14);
        repeat (20) @(negedge clk);
        check("R9 get held while disabled", 32'(ring_get), 32'h0C);
        check("R9 no fetch while disabled", 32'(mem_req), 32'h0);
        check("R9 no writes while disabled", 32'(nlog), 32'd6);
        cfg_write(2'd0, 32'd1);
        wait_get(8'h14);
        check("R9 resume get", 32'(ring_get), 32'h14);
        check("R9 resume offset", 32'(log_ofs[6]), 32'h20);
        check("R9 resume data", log_dat[6], 32'hD000_0001);
    endtask

    task automatic t_cmd_busy;
        @(negedge clk);
        tgt_busy = 1'b1;
        mem[5] = 32'h0002_014C;
        mem[6] = 32'hE000_0001;
        mem[7] = 32'hE000_0002;
        cfg_write(2'd3, 32'h0);
        repeat (30) @(negedge clk);
        check("R8 only pre-command write done", 32'(nlog), 32'd8);
        check("R8 pre-command offset", 32'(log_ofs[7]), 32'h14C);
        check("R8 command held while busy", 32'(wr_valid), 32'h0);
        check("R3 get wrapped to zero", 32'(ring_get), 32'h0);
        tgt_busy = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 command issued after busy", 32'(nlog), 32'd9);
        check("R8 command offset", 32'(log_ofs[8]), 32'h150);
        check("R8 command data", log_dat[8], 32'hE000_0002);
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_count();
        t_wrap();
        t_put_bits();
        t_enable();
        t_cmd_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule